// File: doc/BRIEF.md
# Threshold-Gate Array Multiplier

This block multiplies two unsigned operands of `N` bits each and gives the full `2N`-bit product. It has no clock and no state. It is built only from linear threshold units. Each unit adds up weighted binary inputs and fires when the total reaches its threshold. The first layer forms the `N*N` partial-product bits. Each of those units takes one multiplicand bit and one multiplier bit. Both weights are +1 and the threshold is 2, so the unit behaves as an AND gate.

The other two layers add the partial-product rows in a single step. One hidden group of units stands behind each product bit `k`. That group sees two things. The first is the partial products whose indices sum to `k`. The second is every lower column, scaled down by a power of two for each place of distance. The hidden units come in pairs, and each pair shares an odd threshold. Exactly one unit of a pair fires, except for the pair whose threshold equals the carry-adjusted column total. In that pair both units fire. An output unit set just above half the hidden count therefore reads the parity of that total, and that parity is the product bit. Positions that are always zero are never built, so the logic depth stays at three layers whatever the width.

The block is meant to be dropped into a datapath where a fixed-latency combinational product is wanted. `N` may be any value of 1 or more.

Top module: `tmul_top`

## Requirements
- R1: For every pair of operands, `prod_o` equals the unsigned product `mcand_i * mplier_i`, zero-extended to `2N` bits.
- R2: When either operand is zero, every bit of `prod_o` is 0.
- R3: When one operand is 1, `prod_o` equals the other operand, with zeros in bits `2N-1` down to `N`.
- R4: Bit 0 of `prod_o` is the AND of bit 0 of `mcand_i` and bit 0 of `mplier_i`.
- R5: With both operands at their all-ones value, `prod_o` equals `(2^N-1)^2`. For `N >= 2`, its top bit `2N-1` is 1 and that value is reached only through carries from the lower columns.
- R6: When `mplier_i` holds a single 1 in bit position `j`, `prod_o` equals `mcand_i` shifted left by `j` places.
- R7: The product follows the operands without any clock edge. A new operand pair is reflected on `prod_o` within the same time step.
- R8: Exchanging the two operands leaves `prod_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | N | Unsigned multiplicand |
| mplier_i | input | N | Unsigned multiplier |
| prod_o | output | 2N | Unsigned product |

## Verification
The hardest states to reach are those where a column's scaled total lands exactly on one of its hidden thresholds. The top product bit is also hard to reach, because it holds no partial products and depends only on carries. The bench sweeps every operand pair of a 4-bit instance, so every threshold boundary of every column is hit, including the all-ones case that sets the carry-only top bit. A separate 8-bit instance is then driven with thousands of pseudo-random pairs, plus the all-ones and single-bit multiplier patterns. This covers the deeper carry chains that a small sweep cannot build.

// File: rtl/tmul_pkg.sv
package tmul_pkg;

    // Number of partial-product bits a_i*b_j with i+j == k.
    function automatic int col_count(input int n, input int k);
        if (k < 0 || k > 2 * n - 2) return 0;
        return (k < n) ? (k + 1) : (2 * n - 1 - k);
    endfunction

    // Largest weighted total seen by column k, scaled by 2^k.
    function automatic longint max_weight(input int n, input int k);
        longint s;
        s = 0;
        for (int l = 0; l <= k; l++) begin
            s += longint'(col_count(n, l)) << l;
        end
        return s;
    endfunction

    // Number of hidden threshold pairs needed for column k.
    function automatic int pair_count(input int n, input int k);
        longint q;
        q = max_weight(n, k) >> k;
        return int'((q + 1) / 2);
    endfunction

endpackage

// File: rtl/tmul_and_layer.sv
module tmul_and_layer #(
    parameter int N  = 4,
    parameter int W1 = 1,
    parameter int W2 = 1,
    parameter int TH = 2,
    localparam int PP = N * N
) (
    input  logic [N-1:0]  mcand_i,
    input  logic [N-1:0]  mplier_i,
    output logic [PP-1:0] pp_o
);

    // One threshold unit per partial product; index i*N+j carries a_i*b_j.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                pp_o[i*N+j] = ((int'(mcand_i[i]) * W1) + (int'(mplier_i[j]) * W2)) >= TH;
            end
        end
    end

endmodule

// File: rtl/tmul_col.sv
module tmul_col
    import tmul_pkg::*;
#(
    parameter int N  = 4,
    parameter int K  = 0,
    localparam int PP  = N * N,
    localparam int SW  = 2 * N + 2,
    localparam int NP  = pair_count(N, K),
    localparam int NPA = (NP > 0) ? NP : 1
) (
    input  logic [PP-1:0] pp_i,
    output logic          bit_o
);

    logic [SW-1:0]  wsum_d;
    logic [NPA-1:0] pos_d;
    logic [NPA-1:0] neg_d;
    int             fired_d;

    // Weighted total: column l enters with weight 2^l, thresholds scaled by 2^K.
    always_comb begin
        logic [SW-1:0] term;
        wsum_d = '0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                term = SW'(pp_i[i*N+j]) << (i + j);
                if (i + j > K) term = '0;
                wsum_d = wsum_d + term;
            end
        end
    end

    generate
        if (NP > 0) begin : g_hidden
            for (genvar t = 0; t < NP; t++) begin : g_pair
                localparam logic [SW-1:0] TH_POS = SW'(2 * t + 1) << K;
                localparam logic [SW-1:0] TH_NEG = (SW'(2 * t + 2) << K) - SW'(1);
                // Excitatory unit: fires once the scaled total reaches 2t+1.
                assign pos_d[t] = (wsum_d >= TH_POS);
                // Inhibitory unit: fires while the scaled total stays below 2t+2.
                assign neg_d[t] = (wsum_d <= TH_NEG);
            end
        end else begin : g_empty
            assign pos_d = '0;
            assign neg_d = '0;
        end
    endgenerate

    // Output unit: threshold just above half the hidden units reads the parity.
    always_comb begin
        fired_d = $countones({pos_d, neg_d});
        bit_o   = (NP > 0) && (fired_d >= NP + 1);
    end

endmodule

// File: rtl/tmul_top.sv
module tmul_top #(
    parameter int N = 4,
    localparam int PP = N * N,
    localparam int PW = 2 * N
) (
    input  logic [N-1:0]  mcand_i,
    input  logic [N-1:0]  mplier_i,
    output logic [PW-1:0] prod_o
);

    logic [PP-1:0] pp_d;

    tmul_and_layer #(
        .N (N),
        .W1(1),
        .W2(1),
        .TH(2)
    ) and_i (
        .mcand_i (mcand_i),
        .mplier_i(mplier_i),
        .pp_o    (pp_d)
    );

    generate
        for (genvar k = 0; k < PW; k++) begin : g_col
            tmul_col #(
                .N(N),
                .K(k)
            ) col_i (
                .pp_i (pp_d),
                .bit_o(prod_o[k])
            );
        end
    endgenerate

endmodule

// File: rtl/tmul_chk.sv
module tmul_chk #(
    parameter int N = 4,
    localparam int PW = 2 * N
) (
    input logic [N-1:0]  mcand_i,
    input logic [N-1:0]  mplier_i,
    input logic [PW-1:0] prod_o
);

    logic [PW-1:0] ref_d;
    logic [PW-1:0] ones_sq;

    always_comb begin
        ref_d   = PW'(mcand_i) * PW'(mplier_i);
        ones_sq = PW'({N{1'b1}}) * PW'({N{1'b1}});
        AST_PRODUCT_EXACT: assert (prod_o == ref_d);                                     // R1
        AST_ZERO_OPERAND:  assert (!(mcand_i == '0 || mplier_i == '0) || prod_o == '0);   // R2
        AST_UNIT_OPERAND:  assert (!(mplier_i == N'(1)) || prod_o == PW'(mcand_i));       // R3
        AST_LSB_AND:       assert (prod_o[0] == (mcand_i[0] & mplier_i[0]));              // R4
        AST_BOUNDED:       assert (prod_o <= ones_sq);                                    // R5
    end

endmodule

bind tmul_top tmul_chk #(.N(N)) chk_i (
    .mcand_i (mcand_i),
    .mplier_i(mplier_i),
    .prod_o  (prod_o)
);

// File: tb/tmul_top_tb_top.sv
module tmul_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int NW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    logic [NS-1:0]   a_s, b_s;
    logic [2*NS-1:0] p_s;
    logic [NW-1:0]   a_w, b_w;
    logic [2*NW-1:0] p_w;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmul_top #(.N(NS)) dut_i (.mcand_i(a_s), .mplier_i(b_s), .prod_o(p_s));
    tmul_top #(.N(NW)) dut_w (.mcand_i(a_w), .mplier_i(b_w), .prod_o(p_w));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [2*NS-1:0] keep;
        int unsigned     ra, rb;
        a_s = '0; b_s = '0; a_w = '0; b_w = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: initial all-zero operands
        check("R2 zero after reset", 64'(p_s), 64'(0));
        check("R2 zero after reset wide", 64'(p_w), 64'(0));

        // R1 and R8: exhaustive sweep of the small instance
        for (int a = 0; a < (1 << NS); a++) begin
            for (int b = 0; b < (1 << NS); b++) begin
                @(posedge clk); #1;
                a_s = NS'(a); b_s = NS'(b);
                @(negedge clk);
                check("R1 exhaustive", 64'(p_s), 64'(a * b));
                keep = p_s;
                check("R4 lsb", 64'(p_s[0]), 64'((a & b) & 1));
                if (a == 0 || b == 0) check("R2 zero operand", 64'(p_s), 64'(0));
                if (b == 1) check("R3 unit multiplier", 64'(p_s), 64'(a));
                @(posedge clk); #1;
                a_s = NS'(b); b_s = NS'(a);
                @(negedge clk);
                check("R8 swapped operands", 64'(p_s), 64'(keep));
            end
        end

        // R5: all-ones operands, top bit reached by carries only
        @(posedge clk); #1;
        a_s = '1; b_s = '1; a_w = '1; b_w = '1;
        @(negedge clk);
        check("R5 max small", 64'(p_s), 64'(225));
        check("R5 top bit small", 64'(p_s[2*NS-1]), 64'(1));
        check("R5 max wide", 64'(p_w), 64'(65025));
        check("R5 top bit wide", 64'(p_w[2*NW-1]), 64'(1));

        // R6: single-bit multiplier shifts the multiplicand
        for (int j = 0; j < NW; j++) begin
            @(posedge clk); #1;
            a_w = 8'hB7; b_w = NW'(1) << j;
            @(negedge clk);
            check("R6 shift by multiplier bit", 64'(p_w), 64'(32'hB7) << j);
        end

        // R3 on the wide instance
        @(posedge clk); #1;
        a_w = 8'h01; b_w = 8'hC9;
        @(negedge clk);
        check("R3 unit multiplicand wide", 64'(p_w), 64'(8'hC9));

        // R7: operand change seen without any clock edge
        @(negedge clk);
        a_w = 8'd200; b_w = 8'd17;
        #1;
        check("R7 no clock needed", 64'(p_w), 64'(3400));
        a_w = 8'd13; b_w = 8'd251;
        #1;
        check("R7 second change same phase", 64'(p_w), 64'(3263));

        // R1: random pairs on the wide instance
        for (int n = 0; n < 3000; n++) begin
            @(posedge clk); #1;
            ra = $urandom() & 32'hFF;
            rb = $urandom() & 32'hFF;
            a_w = NW'(ra); b_w = NW'(rb);
            @(negedge clk);
            check("R1 random wide", 64'(p_w), 64'(ra) * 64'(rb));
        end

        finish_run();
    end

endmodule